// File: doc/BRIEF.md
# Upscaling SVGA Framebuffer Scanout

This block produces an 800x600, 60 Hz raster from a 40 MHz pixel clock. The picture comes from a 160x144 framebuffer of 2-bit gray shades, and each stored pixel is drawn as a 4x4 square of screen pixels. The resulting 640x576 picture sits in the middle of the screen. A border of 80 columns is left and right of it, and a border of 12 lines is above and below it. The framebuffer is an external memory with a synchronous read port: the block presents an address and a read enable, and the shade comes back one clock later.

A line counter and a frame counter walk the raster. An address generator turns their values into a framebuffer index while the raster is inside the picture window. An output stage then turns the returned shade into a drive level. Sync pulses and the window flag go through the same number of register stages as the pixel data, so every output describes one and the same raster position. The 2-bit level drives the red, green and blue outputs together.

All raster, source-size and scale figures are parameters, and the borders are derived from them. The defaults give the mode described above.

Top module: `svga_upscale_scanout`

## Requirements
- R1: A line lasts H_ACTIVE+H_FP+H_SYNC+H_BP clocks (1056 by default). Hsync is active high for H_SYNC clocks (128), starting H_ACTIVE+H_FP clocks (840) after the first visible pixel of the line.
- R2: A frame lasts V_ACTIVE+V_FP+V_SYNC+V_BP lines (628 by default). Vsync is active high for V_SYNC lines (4), starting at line V_ACTIVE+V_FP (601). Vsync changes only at the first column of a line.
- R3: At screen column x and line y inside the picture window, the output level is 3 minus the stored shade at index ((y-VB)>>SCALE_LG)*SRC_W + ((x-HB)>>SCALE_LG). HB=(H_ACTIVE-SRC_W*2^SCALE_LG)/2 (80 by default) and VB=(V_ACTIVE-SRC_H*2^SCALE_LG)/2 (12 by default). The window covers columns HB to HB+SRC_W*2^SCALE_LG-1 and lines VB to VB+SRC_H*2^SCALE_LG-1.
- R4: At every position outside the picture window, including the border and all blanking, the output level is 0 on all three colour outputs.
- R5: The stored shade encoding is 0 for white and 3 for black. A stored 0 drives level 3 and a stored 3 drives level 0.
- R6: The read enable is high exactly while the counters are inside the picture window, and the address is then the index given in R3. The read enable and address lead the displayed pixel by two clocks. The address is always below SRC_W*SRC_H.
- R7: While reset is held, hsync, vsync, the colour levels and the read enable are all 0.
- R8: Hsync, vsync and the colour level leave the block with the same two-clock delay from the counters, so all of them describe the same raster position.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock (40 MHz in the default mode) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fb_rd_en | output | 1 | Framebuffer read strobe |
| fb_addr | output | ADDR_W | Framebuffer read index, row-major |
| fb_rd_data | input | 2 | Shade returned by the framebuffer one clock after the read |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| red | output | 2 | Red drive level |
| green | output | 2 | Green drive level |
| blue | output | 2 | Blue drive level |

## Verification
The two functions that meet in one cycle are the line-counter wrap and the frame-counter step. These coincide at the last column of each line, and at the last line they also coincide with the frame wrap. That is where a misaligned sync stage or a wrong address would show. The bench locks onto a rising edge of vsync and then follows a full frame with its own model of the raster, built from the requirements. On every clock it compares hsync, vsync, level, read enable and address, so each line boundary and the frame wrap are judged in the very cycle they occur. This is done for a patterned framebuffer, for all-white and for all-black contents, using a reduced raster. A separate instance with the default parameters is measured for line period and hsync width.

// File: rtl/svga_scan_pkg.sv
package svga_scan_pkg;

  typedef logic [1:0] shade_t;

  typedef struct packed {
    logic hs;
    logic vs;
    logic win;
  } scan_ctl_t;

endpackage

// File: rtl/svga_scan_timing.sv
module svga_scan_timing #(
  parameter int H_ACTIVE = 800,
  parameter int H_FP     = 40,
  parameter int H_SYNC   = 128,
  parameter int H_BP     = 88,
  parameter int V_ACTIVE = 600,
  parameter int V_FP     = 1,
  parameter int V_SYNC   = 4,
  parameter int V_BP     = 23,
  parameter int HCW      = 11,
  parameter int VCW      = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic [HCW-1:0] hcnt,
  output logic [VCW-1:0] vcnt,
  output logic           hs_raw,
  output logic           vs_raw
);

  localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP;
  localparam logic [HCW-1:0] H_LAST = HCW'(H_TOTAL - 1);
  localparam logic [VCW-1:0] V_LAST = VCW'(V_TOTAL - 1);
  localparam logic [HCW-1:0] HS_ON  = HCW'(H_ACTIVE + H_FP);
  localparam logic [HCW-1:0] HS_OFF = HCW'(H_ACTIVE + H_FP + H_SYNC);
  localparam logic [VCW-1:0] VS_ON  = VCW'(V_ACTIVE + V_FP);
  localparam logic [VCW-1:0] VS_OFF = VCW'(V_ACTIVE + V_FP + V_SYNC);

  logic [HCW-1:0] h_nxt;
  logic [VCW-1:0] v_nxt;
  logic           h_end;
  logic           v_end;

  assign h_end = (hcnt == H_LAST);
  assign v_end = (vcnt == V_LAST);

  always_comb begin
    h_nxt = hcnt + 1'b1;
    v_nxt = vcnt;
    if (h_end) begin
      h_nxt = '0;
      v_nxt = v_end ? '0 : vcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else begin
      hcnt <= h_nxt;
      vcnt <= v_nxt;
    end
  end

  assign hs_raw = (hcnt >= HS_ON) && (hcnt < HS_OFF);
  assign vs_raw = (vcnt >= VS_ON) && (vcnt < VS_OFF);

  // R1: line counter steps by one and wraps after the last column
  a_r1_line_step: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt != H_LAST) |=> (hcnt == $past(hcnt) + 1'b1));
  a_r1_line_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt == H_LAST) |=> (hcnt == '0));
  // R2: frame counter moves only at a line wrap and wraps after the last line
  a_r2_frame_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt != H_LAST) |=> $stable(vcnt));
  a_r2_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt == H_LAST && vcnt == V_LAST) |=> (vcnt == '0 && hcnt == '0));

endmodule

// File: rtl/svga_scan_addr.sv
module svga_scan_addr #(
  parameter int SRC_W    = 160,
  parameter int SRC_H    = 144,
  parameter int SCALE_LG = 2,
  parameter int HB       = 80,
  parameter int VB       = 12,
  parameter int HCW      = 11,
  parameter int VCW      = 10,
  parameter int ADDR_W   = 15
) (
  input  logic [HCW-1:0]    hcnt,
  input  logic [VCW-1:0]    vcnt,
  output logic              in_win,
  output logic [ADDR_W-1:0] addr
);

  localparam logic [HCW-1:0]    X_LO  = HCW'(HB);
  localparam logic [HCW-1:0]    X_HI  = HCW'(HB + (SRC_W << SCALE_LG));
  localparam logic [VCW-1:0]    Y_LO  = VCW'(VB);
  localparam logic [VCW-1:0]    Y_HI  = VCW'(VB + (SRC_H << SCALE_LG));
  localparam logic [ADDR_W-1:0] ROW_W = ADDR_W'(SRC_W);

  logic [ADDR_W-1:0] col_src;
  logic [ADDR_W-1:0] row_src;

  assign in_win = (hcnt >= X_LO) && (hcnt < X_HI) &&
                  (vcnt >= Y_LO) && (vcnt < Y_HI);

  assign col_src = ADDR_W'((hcnt - X_LO) >> SCALE_LG);
  assign row_src = ADDR_W'((vcnt - Y_LO) >> SCALE_LG);

  always_comb begin
    addr = '0;
    if (in_win) begin
      addr = row_src * ROW_W + col_src;
    end
  end

endmodule

// File: rtl/svga_scan_pipe.sv
module svga_scan_pipe
  import svga_scan_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   hs_raw,
  input  logic   vs_raw,
  input  logic   in_win,
  input  shade_t rd_data,
  output logic   hsync,
  output logic   vsync,
  output shade_t level
);

  scan_ctl_t s1_q;
  scan_ctl_t s1_d;
  shade_t    lvl_d;

  always_comb begin
    s1_d.hs  = hs_raw;
    s1_d.vs  = vs_raw;
    s1_d.win = in_win;
    // inverted shade: stored white (0) drives the top level
    lvl_d = s1_q.win ? ~rd_data : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= '0;
      hsync <= 1'b0;
      vsync <= 1'b0;
      level <= '0;
    end else begin
      s1_q  <= s1_d;
      hsync <= s1_q.hs;
      vsync <= s1_q.vs;
      level <= lvl_d;
    end
  end

  // R8: a sync edge on the output follows the raw sync two clocks earlier
  a_r8_hs_delay: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsync) |-> $past(hs_raw, 2));
  a_r8_vs_delay: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync) |-> $past(vs_raw, 2));

endmodule

// File: rtl/svga_upscale_scanout.sv
module svga_upscale_scanout
  import svga_scan_pkg::*;
#(
  parameter int H_ACTIVE = 800,
  parameter int H_FP     = 40,
  parameter int H_SYNC   = 128,
  parameter int H_BP     = 88,
  parameter int V_ACTIVE = 600,
  parameter int V_FP     = 1,
  parameter int V_SYNC   = 4,
  parameter int V_BP     = 23,
  parameter int SRC_W    = 160,
  parameter int SRC_H    = 144,
  parameter int SCALE_LG = 2,
  parameter int ADDR_W   = $clog2(SRC_W * SRC_H)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              fb_rd_en,
  output logic [ADDR_W-1:0] fb_addr,
  input  logic [1:0]        fb_rd_data,
  output logic              hsync,
  output logic              vsync,
  output logic [1:0]        red,
  output logic [1:0]        green,
  output logic [1:0]        blue
);

  localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP;
  localparam int HCW     = $clog2(H_TOTAL);
  localparam int VCW     = $clog2(V_TOTAL);
  localparam int HB      = (H_ACTIVE - (SRC_W << SCALE_LG)) / 2;
  localparam int VB      = (V_ACTIVE - (SRC_H << SCALE_LG)) / 2;
  localparam int DEPTH   = SRC_W * SRC_H;

  logic           rst_q1;
  logic           rst_int;
  logic [HCW-1:0] hcnt;
  logic [VCW-1:0] vcnt;
  logic           hs_raw;
  logic           vs_raw;
  logic           in_win;
  shade_t         level;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1  <= 1'b0;
      rst_int <= 1'b0;
    end else begin
      rst_q1  <= 1'b1;
      rst_int <= rst_q1;
    end
  end

  svga_scan_timing #(
    .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .HCW(HCW), .VCW(VCW)
  ) timing_i (
    .clk(clk), .rst_n(rst_int),
    .hcnt(hcnt), .vcnt(vcnt), .hs_raw(hs_raw), .vs_raw(vs_raw)
  );

  svga_scan_addr #(
    .SRC_W(SRC_W), .SRC_H(SRC_H), .SCALE_LG(SCALE_LG),
    .HB(HB), .VB(VB), .HCW(HCW), .VCW(VCW), .ADDR_W(ADDR_W)
  ) addr_i (
    .hcnt(hcnt), .vcnt(vcnt), .in_win(in_win), .addr(fb_addr)
  );

  assign fb_rd_en = in_win;

  svga_scan_pipe pipe_i (
    .clk(clk), .rst_n(rst_int),
    .hs_raw(hs_raw), .vs_raw(vs_raw), .in_win(in_win),
    .rd_data(fb_rd_data),
    .hsync(hsync), .vsync(vsync), .level(level)
  );

  assign red   = level;
  assign green = level;
  assign blue  = level;

  // R6: every read stays inside the framebuffer
  a_r6_addr_range: assert property (@(posedge clk) disable iff (!rst_int)
    fb_rd_en |-> ({1'b0, fb_addr} < (ADDR_W + 1)'(DEPTH)));
  // R4: nothing is driven while either sync pulse is active
  a_r4_dark_in_sync: assert property (@(posedge clk) disable iff (!rst_int)
    (hsync || vsync) |-> (level == '0));
  // R1: hsync rises for the counter column two clocks back
  a_r1_hsync_start: assert property (@(posedge clk) disable iff (!rst_int)
    $rose(hsync) |-> ($past(hcnt, 2) == HCW'(H_ACTIVE + H_FP)));
  // R7: no read request while reset is held
  a_r7_quiet_reset: assert property (@(posedge clk)
    !rst_int |-> !fb_rd_en);

endmodule

// File: tb/svga_upscale_scanout_tb_top.sv
module svga_upscale_scanout_tb_top;

  localparam int SW = 8, SH = 6, SL = 2, SC = 4;
  localparam int HA = 40, HF = 4, HS = 8, HP = 4;
  localparam int VA = 28, VF = 1, VS = 2, VP = 3;
  localparam int HT = HA + HF + HS + HP;
  localparam int VT = VA + VF + VS + VP;
  localparam int HB = (HA - SW * SC) / 2;
  localparam int VB = (VA - SH * SC) / 2;
  localparam int DEPTH = SW * SH;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n;
  always #4 clk = ~clk;

  logic          rd_en;
  logic [AW-1:0] addr;
  logic [1:0]    rd_data;
  logic          hsync, vsync;
  logic [1:0]    red, green, blue;
  logic [1:0]    mem [DEPTH];

  svga_upscale_scanout #(
    .H_ACTIVE(HA), .H_FP(HF), .H_SYNC(HS), .H_BP(HP),
    .V_ACTIVE(VA), .V_FP(VF), .V_SYNC(VS), .V_BP(VP),
    .SRC_W(SW), .SRC_H(SH), .SCALE_LG(SL)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .fb_rd_en(rd_en), .fb_addr(addr),
    .fb_rd_data(rd_data), .hsync(hsync), .vsync(vsync),
    .red(red), .green(green), .blue(blue)
  );

  always_ff @(posedge clk) if (rd_en) rd_data <= mem[addr];

  // default-parameter instance, measured for line timing only
  logic        f_rd_en, f_hs, f_vs;
  logic [14:0] f_addr;
  logic [1:0]  f_r, f_g, f_b;
  logic [1:0]  f_data = 2'b01;

  svga_upscale_scanout dut_full (
    .clk(clk), .rst_n(rst_n), .fb_rd_en(f_rd_en), .fb_addr(f_addr),
    .fb_rd_data(f_data), .hsync(f_hs), .vsync(f_vs),
    .red(f_r), .green(f_g), .blue(f_b)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit win(input int h, input int v);
    return h >= HB && h < HB + SW * SC && v >= VB && v < VB + SH * SC;
  endfunction

  function automatic int idx(input int h, input int v);
    return ((v - VB) / SC) * SW + (h - HB) / SC;
  endfunction

  function automatic int exp_lvl(input int h, input int v);
    return win(h, v) ? 3 - int'(mem[idx(h, v)]) : 0;
  endfunction

  task automatic fill_pattern();
    for (int a = 0; a < DEPTH; a++) mem[a] = 2'((a * 5 + a / 7) & 3);
  endtask

  task automatic fill_const(input logic [1:0] val);
    for (int a = 0; a < DEPTH; a++) mem[a] = val;
  endtask

  // R7: quiet outputs while reset is held
  task automatic t_reset();
    repeat (4) @(negedge clk);
    chk(hsync == 1'b0, "R7 hsync in reset", int'(hsync), 0);
    chk(vsync == 1'b0, "R7 vsync in reset", int'(vsync), 0);
    chk(red == 2'd0 && green == 2'd0 && blue == 2'd0, "R7 level in reset", int'(red), 0);
    chk(rd_en == 1'b0, "R7 read enable in reset", int'(rd_en), 0);
    chk(f_hs == 1'b0 && f_rd_en == 1'b0, "R7 default instance in reset", int'(f_hs), 0);
  endtask

  // follow one whole frame from a vsync rise and compare every clock
  task automatic t_frame(input string lvl_tag);
    logic prev_vs;
    int h, v, h2, v2;
    prev_vs = vsync;
    @(negedge clk);
    while (!(vsync && !prev_vs)) begin
      prev_vs = vsync;
      @(negedge clk);
    end
    h = 0;
    v = VA + VF;
    for (int i = 0; i < HT * VT; i++) begin
      chk(hsync == (h >= HA + HF && h < HA + HF + HS), "R1 hsync", int'(hsync), h);
      chk(vsync == (v >= VA + VF && v < VA + VF + VS), "R2 vsync", int'(vsync), v);
      chk(int'(red) == exp_lvl(h, v) && green == red && blue == red,
          {lvl_tag, " R4 level"}, int'(red), exp_lvl(h, v));
      h2 = h + 2;
      v2 = v;
      if (h2 >= HT) begin
        h2 -= HT;
        v2 = (v + 1) % VT;
      end
      chk(rd_en == win(h2, v2), "R6 read enable", int'(rd_en), int'(win(h2, v2)));
      if (win(h2, v2))
        chk(int'(addr) == idx(h2, v2), "R6 address", int'(addr), idx(h2, v2));
      @(negedge clk);
      h++;
      if (h == HT) begin
        h = 0;
        v = (v + 1) % VT;
      end
    end
  endtask

  // R1: default mode line period 1056 and hsync width 128
  task automatic t_default_line();
    int period, high;
    logic prev;
    prev = f_hs;
    @(negedge clk);
    while (!(f_hs && !prev)) begin prev = f_hs; @(negedge clk); end
    period = 0;
    high = 0;
    do begin
      if (f_hs) high++;
      chk(!(f_hs && f_r != 2'd0), "R4 default dark in hsync", int'(f_r), 0);
      period++;
      prev = f_hs;
      @(negedge clk);
    end while (!(f_hs && !prev));
    chk(period == 1056, "R1 default line period", period, 1056);
    chk(high == 128, "R1 default hsync width", high, 128);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b1;
    fill_pattern();
    #1 rst_n = 1'b0;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_frame("R3/R8");
    fill_const(2'd0);
    t_frame("R5 white");
    fill_const(2'd3);
    t_frame("R5 black");
    fill_pattern();
    t_frame("R3/R8 again");
    t_default_line();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule